// File: doc/BRIEF.md
# Serial Character Receiver with Per-Character Line Status

This block turns an asynchronous serial input into characters. A baud tick at sixteen times the bit rate drives it. A start bit is qualified at the middle of the bit. Each later bit is then sampled once per bit period, least significant bit first. Every completed character is checked for parity, stop-bit and break conditions. The character and its three error flags are pushed together into a holding queue two entries deep.

A host reaches four byte-wide registers through a plain select/address/strobe port:

| Address | Register | Access |
|---|---|---|
| 0 | Receive buffer | read; reading pops the queue |
| 1 | Interrupt enable | read/write |
| 2 | Line control | read/write |
| 3 | Line status | read; reading clears the error and overrun bits |

A character's error flags reach the line status register only when that character is at the head of the queue. An earlier clean character is therefore reported clean. The flags of the character behind it appear once the earlier one is read out.

The interrupt output is a level. It is the OR of a data-available source and a line-status source, each gated by its own enable bit.

Internally, the sampler hands characters to the holding queue over a valid/ready pair with no back-pressure toward the line. If valid is high while ready is low, the character is lost and the overrun bit is set.

Top module: `serial_rx_lsr`

## Requirements
- R1: After reset, line status reads 0x60, the interrupt output is low, and the receive buffer, interrupt enable and line control registers all read 0x00.
- R2: Line control bits 1:0 select 5, 6, 7 or 8 data bits (00, 01, 10, 11). Data bits arrive least significant first, and unused upper bits of the receive buffer read 0.
- R3: With parity enabled (line control bit 3) and stick parity off, line control bit 4 picks even parity (1) or odd parity (0). A parity bit that does not match sets line status bit 2.
- R4: With stick parity on (line control bit 5), the expected parity bit is the inverse of line control bit 4. A mismatch sets line status bit 2.
- R5: A low stop-bit sample sets line status bit 3. The receiver then waits for the line to return high before it looks for a new start bit.
- R6: A frame in which every sampled bit is low, stop bit included, stores 0x00 with line status bits 3 and 4 set and bit 2 clear. Only one character is stored, however long the line stays low.
- R7: A low pulse shorter than half a bit period is not taken as a start bit, and no character is stored.
- R8: Reading line status clears bits 1 to 4. An immediate second read shows only bit 0 and the fixed bits (0x61 while a character is held). Reading the receive buffer leaves bits 2 to 4 unchanged.
- R9: Error flags follow their own character. A clean character ahead of a flawed one reads with clean status, and the flags of the flawed one appear only after the clean one is read out.
- R10: Reading the receive buffer returns the oldest held character and removes it. Line status bit 0 is 1 exactly while a character is held.
- R11: A character that completes while two characters are held is dropped, and line status bit 1 is set.
- R12: The interrupt output is high exactly when (enable bit 0 and line status bit 0) or (enable bit 2 and any of line status bits 1 to 4). Enable bits 1 and 3 have no effect on it.
- R13: Interrupt enable keeps bits 3:0 and reads the upper bits as 0. Line control keeps all 8 bits. Bit 2 (stop-bit count) and bit 6 (force break) have no effect on reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rx_line | input | 1 | Serial input, idle high |
| sel | input | 1 | Register port select |
| addr | input | 2 | Register address |
| rd_stb | input | 1 | Read strobe; read data is registered and valid the next cycle |
| wr_stb | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, held until the next read |
| irq | output | 1 | Interrupt level |

## Verification
The hardest situation to reach is a flawed character waiting behind a clean one. The interrupt must stay low while the clean one is at the head and rise only after it is read out. The bench sends a clean frame, rewrites line control so that parity checking is on, and sends a frame with a wrong parity bit before any read. Overrun needs a similar sequence: three frames back to back with no reads. A break needs the line held low well past a full frame and then released. Randomized frames cover every word length, each parity mode and injected stop-bit errors against a bench model.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  localparam logic [1:0] A_RXBUF = 2'd0;
  localparam logic [1:0] A_IEN   = 2'd1;
  localparam logic [1:0] A_LCTL  = 2'd2;
  localparam logic [1:0] A_LSTAT = 2'd3;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_HOLD_LOW
  } rx_state_e;

  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
  } rx_err_t;

  typedef struct packed {
    logic [1:0] wlen;
    logic       par_en;
    logic       even;
    logic       stick;
  } line_cfg_t;
endpackage

// File: rtl/rx_frame_check.sv
module rx_frame_check
  import serial_rx_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic [CHAR_W-1:0]              shreg,
  input  logic [1:0]                     wlen,
  input  logic                           par_en,
  input  logic                           even,
  input  logic                           stick,
  input  logic                           par_bit,
  input  logic                           all_zero,
  input  logic                           stop_bit,
  output logic [$clog2(CHAR_W+1)-1:0]    nbits,
  output logic [CHAR_W-1:0]              char_o,
  output rx_err_t                        err_o
);
  localparam int BW    = $clog2(CHAR_W + 1);
  localparam int MIN_W = CHAR_W - 3;

  logic ones;
  logic exp_par;

  always_comb begin
    nbits  = BW'(MIN_W) + BW'(wlen);
    char_o = shreg >> (CHAR_W - int'(nbits));
    ones   = ^char_o;
    if (stick)     exp_par = ~even;
    else if (even) exp_par = ones;
    else           exp_par = ~ones;
    err_o.frm = ~stop_bit;
    err_o.brk = ~stop_bit & all_zero;
    err_o.par = par_en & ~err_o.brk & (par_bit != exp_par);
  end
endmodule

// File: rtl/rx_sampler.sv
module rx_sampler
  import serial_rx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              line_in,
  input  line_cfg_t         cfg,
  output logic              out_valid,
  output logic [CHAR_W-1:0] out_char,
  output rx_err_t           out_err
);
  localparam int TW = $clog2(OVS);
  localparam int BW = $clog2(CHAR_W + 1);
  localparam logic [TW-1:0] MID_T  = TW'(OVS / 2 - 1);
  localparam logic [TW-1:0] LAST_T = TW'(OVS - 1);

  logic [1:0]        sync_q;
  logic              line_s;
  rx_state_e         state_q;
  logic [TW-1:0]     tcnt_q;
  logic [BW-1:0]     bit_q;
  logic [BW-1:0]     nbits;
  logic [CHAR_W-1:0] shreg_q;
  logic              par_q;
  logic              zero_q;
  logic [CHAR_W-1:0] chk_char;
  rx_err_t           chk_err;

  assign line_s = sync_q[1];

  rx_frame_check #(.CHAR_W(CHAR_W)) u_check (
    .shreg    (shreg_q),
    .wlen     (cfg.wlen),
    .par_en   (cfg.par_en),
    .even     (cfg.even),
    .stick    (cfg.stick),
    .par_bit  (par_q),
    .all_zero (zero_q),
    .stop_bit (line_s),
    .nbits    (nbits),
    .char_o   (chk_char),
    .err_o    (chk_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], line_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= RX_IDLE;
      tcnt_q    <= '0;
      bit_q     <= '0;
      shreg_q   <= '0;
      par_q     <= 1'b0;
      zero_q    <= 1'b0;
      out_valid <= 1'b0;
      out_char  <= '0;
      out_err   <= '0;
    end else begin
      out_valid <= 1'b0;
      if (tick) begin
        case (state_q)
          RX_IDLE: begin
            if (!line_s) begin
              state_q <= RX_START;
              tcnt_q  <= '0;
            end
          end
          RX_START: begin
            if (tcnt_q == MID_T) begin
              tcnt_q <= '0;
              if (line_s) begin
                state_q <= RX_IDLE;
              end else begin
                state_q <= RX_DATA;
                bit_q   <= '0;
                shreg_q <= '0;
                zero_q  <= 1'b1;
              end
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
          RX_DATA: begin
            if (tcnt_q == LAST_T) begin
              tcnt_q  <= '0;
              shreg_q <= {line_s, shreg_q[CHAR_W-1:1]};
              if (line_s) zero_q <= 1'b0;
              if (bit_q == nbits - 1'b1) state_q <= cfg.par_en ? RX_PAR : RX_STOP;
              else                       bit_q   <= bit_q + 1'b1;
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
          RX_PAR: begin
            if (tcnt_q == LAST_T) begin
              tcnt_q  <= '0;
              par_q   <= line_s;
              if (line_s) zero_q <= 1'b0;
              state_q <= RX_STOP;
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
          RX_STOP: begin
            if (tcnt_q == LAST_T) begin
              tcnt_q    <= '0;
              out_valid <= 1'b1;
              out_char  <= chk_char;
              out_err   <= chk_err;
              state_q   <= line_s ? RX_IDLE : RX_HOLD_LOW;
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
          RX_HOLD_LOW: begin
            if (line_s) state_q <= RX_IDLE;
          end
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rx_hold_queue.sv
module rx_hold_queue #(
  parameter int DEPTH = 2,
  parameter int PAY_W = 8,
  parameter int TAG_W = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push_valid,
  input  logic [TAG_W+PAY_W-1:0]     push_data,
  output logic                       push_ready,
  input  logic                       pop,
  output logic                       head_valid,
  output logic [PAY_W-1:0]           head_pay,
  output logic                       new_head,
  output logic [TAG_W-1:0]           new_head_tag,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int EW = TAG_W + PAY_W;
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [EW-1:0] slot_q [DEPTH];
  logic [PW-1:0] rd_q, wr_q;
  logic          do_pop, do_push;
  logic [PW-1:0] rd_nx;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  assign do_pop     = pop && (count != '0);
  assign push_ready = (count < FULL) || do_pop;
  assign do_push    = push_valid && push_ready;
  assign rd_nx      = step(rd_q);
  assign head_valid = (count != '0);
  assign head_pay   = slot_q[rd_q][PAY_W-1:0];

  always_comb begin
    new_head     = (count == '0 && do_push) ||
                   (do_pop && count >= CW'(2)) ||
                   (do_pop && count == CW'(1) && do_push);
    new_head_tag = (do_pop && count >= CW'(2)) ? slot_q[rd_nx][EW-1:PAY_W]
                                               : push_data[EW-1:PAY_W];
  end

  always_ff @(posedge clk) begin
    if (do_push) slot_q[wr_q] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      count <= '0;
    end else begin
      if (do_push) wr_q <= step(wr_q);
      if (do_pop)  rd_q <= rd_nx;
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/rx_regs.sv
module rx_regs
  import serial_rx_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic [1:0]        addr,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic [7:0]        wdata,
  input  logic              head_valid,
  input  logic [CHAR_W-1:0] head_char,
  input  logic              new_head,
  input  rx_err_t           new_head_err,
  input  logic              drop,
  output logic              pop,
  output line_cfg_t         cfg,
  output logic [3:0]        ier_o,
  output logic [3:0]        flags_o,
  output logic [7:0]        rdata,
  output logic              irq
);
  logic       rd_hit, wr_hit, lsr_rd;
  logic [3:0] ier_q;
  logic [7:0] lcr_q;
  rx_err_t    err_q, err_d;
  logic       ovr_q, ovr_d;
  logic [7:0] lsr_val, rd_mux;

  assign rd_hit = sel & rd_stb;
  assign wr_hit = sel & wr_stb;
  assign pop    = rd_hit && (addr == A_RXBUF);
  assign lsr_rd = rd_hit && (addr == A_LSTAT);

  assign cfg.wlen   = lcr_q[1:0];
  assign cfg.par_en = lcr_q[3];
  assign cfg.even   = lcr_q[4];
  assign cfg.stick  = lcr_q[5];
  assign ier_o      = ier_q;
  assign flags_o    = {err_q.brk, err_q.frm, err_q.par, ovr_q};

  always_comb begin
    err_d = lsr_rd ? '0 : err_q;
    if (new_head) err_d = rx_err_t'(err_d | new_head_err);
    ovr_d = (ovr_q && !lsr_rd) || drop;
  end

  assign lsr_val = {1'b0, 2'b11, err_q.brk, err_q.frm, err_q.par, ovr_q, head_valid};

  always_comb begin
    case (addr)
      A_RXBUF: rd_mux = head_valid ? 8'(head_char) : 8'h00;
      A_IEN:   rd_mux = {4'b0000, ier_q};
      A_LCTL:  rd_mux = lcr_q;
      default: rd_mux = lsr_val;
    endcase
  end

  assign irq = (ier_q[0] & head_valid) | (ier_q[2] & (ovr_q | (|err_q)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ier_q <= '0;
      lcr_q <= '0;
      err_q <= '0;
      ovr_q <= 1'b0;
      rdata <= '0;
    end else begin
      err_q <= err_d;
      ovr_q <= ovr_d;
      if (rd_hit) rdata <= rd_mux;
      if (wr_hit && addr == A_IEN)  ier_q <= wdata[3:0];
      if (wr_hit && addr == A_LCTL) lcr_q <= wdata;
    end
  end
endmodule

// File: rtl/serial_rx_lsr.sv
module serial_rx_lsr
  import serial_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int CHAR_W     = 8,
  parameter int HOLD_DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       rx_line,
  input  logic       sel,
  input  logic [1:0] addr,
  input  logic       rd_stb,
  input  logic       wr_stb,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq
);
  localparam int CNT_W = $clog2(HOLD_DEPTH + 1);
  localparam int TAG_W = $bits(rx_err_t);

  line_cfg_t          cfg;
  logic               rx_valid, rx_ready;
  logic [CHAR_W-1:0]  rx_char;
  rx_err_t            rx_err;
  logic               host_pop;
  logic               head_valid;
  logic [CHAR_W-1:0]  head_char;
  logic               new_head;
  logic [TAG_W-1:0]   new_head_tag;
  logic [CNT_W-1:0]   q_count;
  logic [3:0]         ier_w;
  logic [3:0]         flags_w;

  rx_sampler #(.OVS(OVERSAMPLE), .CHAR_W(CHAR_W)) u_sampler (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (baud_tick),
    .line_in   (rx_line),
    .cfg       (cfg),
    .out_valid (rx_valid),
    .out_char  (rx_char),
    .out_err   (rx_err)
  );

  rx_hold_queue #(.DEPTH(HOLD_DEPTH), .PAY_W(CHAR_W), .TAG_W(TAG_W)) u_queue (
    .clk          (clk),
    .rst_n        (rst_n),
    .push_valid   (rx_valid),
    .push_data    ({rx_err, rx_char}),
    .push_ready   (rx_ready),
    .pop          (host_pop),
    .head_valid   (head_valid),
    .head_pay     (head_char),
    .new_head     (new_head),
    .new_head_tag (new_head_tag),
    .count        (q_count)
  );

  rx_regs #(.CHAR_W(CHAR_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .sel          (sel),
    .addr         (addr),
    .rd_stb       (rd_stb),
    .wr_stb       (wr_stb),
    .wdata        (wdata),
    .head_valid   (head_valid),
    .head_char    (head_char),
    .new_head     (new_head),
    .new_head_err (rx_err_t'(new_head_tag)),
    .drop         (rx_valid & ~rx_ready),
    .pop          (host_pop),
    .cfg          (cfg),
    .ier_o        (ier_w),
    .flags_o      (flags_w),
    .rdata        (rdata),
    .irq          (irq)
  );
endmodule

// File: rtl/serial_rx_lsr_chk.sv
module serial_rx_lsr_chk #(
  parameter int DEPTH = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       sel,
  input logic [1:0]                 addr,
  input logic                       rd_stb,
  input logic [2:0]                 rdata_hi,
  input logic                       irq,
  input logic [3:0]                 ier,
  input logic [3:0]                 flags,
  input logic [$clog2(DEPTH+1)-1:0] q_count,
  input logic                       rx_valid,
  input logic                       rx_ready,
  input logic                       host_pop,
  input logic                       new_head
);
  localparam int CW = $clog2(DEPTH + 1);
  logic lsr_rd;
  assign lsr_rd = sel && rd_stb && (addr == 2'd3);

  // R11
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= CW'(DEPTH));

  // R11
  drop_sets_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> flags[0]);

  // R8
  status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !new_head && !(rx_valid && !rx_ready)) |=> (flags == 4'b0000));

  // R12
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ier[0] && !ier[2]) |-> !irq);

  // R12
  irq_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ier[0] && q_count != '0) |-> irq);

  // R10
  pop_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_pop && q_count == CW'(1) && !rx_valid) |=> (q_count == '0));

  // R1
  idle_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lsr_rd |=> (rdata_hi == 3'b011));
endmodule

bind serial_rx_lsr serial_rx_lsr_chk #(.DEPTH(HOLD_DEPTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sel      (sel),
  .addr     (addr),
  .rd_stb   (rd_stb),
  .rdata_hi (rdata[7:5]),
  .irq      (irq),
  .ier      (ier_w),
  .flags    (flags_w),
  .q_count  (q_count),
  .rx_valid (rx_valid),
  .rx_ready (rx_ready),
  .host_pop (host_pop),
  .new_head (new_head)
);

// File: tb/serial_rx_lsr_bench.sv
module serial_rx_lsr_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int BIT_CLKS   = 16 * TICK_DIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       rx_line = 1'b1;
  logic       sel = 1'b0, rd_stb = 1'b0, wr_stb = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq;
  int         total = 0, bad = 0, divcnt = 0;
  logic       done = 1'b0;

  serial_rx_lsr u_serial_rx_lsr (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rx_line(rx_line),
    .sel(sel), .addr(addr), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    divcnt    <= (divcnt == TICK_DIV - 1) ? 0 : divcnt + 1;
    baud_tick <= (divcnt == TICK_DIV - 1);
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); sel = 1; wr_stb = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; wr_stb = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); sel = 1; rd_stb = 1; addr = a;
    @(negedge clk); sel = 0; rd_stb = 0; d = rdata;
  endtask

  task automatic drive_bit(input logic b);
    @(negedge clk); rx_line = b;
    repeat (BIT_CLKS - 1) @(negedge clk);
  endtask

  task automatic idle_bits(input int n);
    @(negedge clk); rx_line = 1'b1;
    repeat (n * BIT_CLKS) @(negedge clk);
  endtask

  function automatic logic calc_par(input logic [7:0] d, input int wl, input logic even, input logic stick);
    logic [7:0] m = 8'((1 << (5 + wl)) - 1);
    logic ones = ^(d & m);
    if (stick) return ~even;
    return even ? ones : ~ones;
  endfunction

  task automatic send(input logic [7:0] d, input int wl, input logic pen, input logic even,
                      input logic stick, input logic bad_par, input logic bad_stop);
    drive_bit(1'b0);
    for (int i = 0; i < 5 + wl; i++) drive_bit(d[i]);
    if (pen) drive_bit(calc_par(d, wl, even, stick) ^ bad_par);
    drive_bit(~bad_stop);
    idle_bits(2);
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'h1234abcd));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 irq", irq, 0);
    rd(2'd3, v); check("R1 lsr", v, 8'h60);
    rd(2'd0, v); check("R1 rbr", v, 8'h00);
    rd(2'd1, v); check("R1 ier", v, 8'h00);
    rd(2'd2, v); check("R1 lcr", v, 8'h00);

    // R13 register readback
    wr(2'd1, 8'hFF); rd(2'd1, v); check("R13 ier", v, 8'h0F);
    wr(2'd2, 8'hFF); rd(2'd2, v); check("R13 lcr", v, 8'hFF);

    // R7 false start
    wr(2'd1, 8'h05); wr(2'd2, 8'h03);
    @(negedge clk); rx_line = 1'b0;
    repeat (4 * TICK_DIV) @(negedge clk);
    idle_bits(2);
    rd(2'd3, v); check("R7 lsr", v, 8'h60);
    check("R7 irq", irq, 0);

    // R2 five-bit word, upper bits zero; R13 stop count and force break ignored
    wr(2'd1, 8'h00); wr(2'd2, 8'h44);
    send(8'hFF, 0, 0, 0, 0, 0, 0);
    rd(2'd3, v); check("R2 lsr", v, 8'h61);
    rd(2'd0, v); check("R2 rbr 5bit", v, 8'h1F);
    rd(2'd3, v); check("R10 lsr empty", v, 8'h60);

    // R9 clean char ahead of a bad-parity char
    wr(2'd1, 8'h04); wr(2'd2, 8'h03);
    send(8'h5A, 3, 0, 0, 0, 0, 0);
    wr(2'd2, 8'h0B);
    send(8'h92, 3, 1, 0, 0, 1, 0);
    check("R9 irq low while clean head", irq, 0);
    rd(2'd3, v); check("R9 clean lsr", v, 8'h61);
    rd(2'd0, v); check("R9 first rbr", v, 8'h5A);
    @(negedge clk);
    check("R9 irq rises", irq, 1);
    rd(2'd3, v); check("R9 pe lsr", v, 8'h65);
    check("R8 irq dropped", irq, 0);
    rd(2'd3, v); check("R8 second lsr", v, 8'h61);
    rd(2'd0, v); check("R9 second rbr", v, 8'h92);
    rd(2'd3, v); check("R10 lsr empty", v, 8'h60);

    // R8 buffer read does not clear error bits
    send(8'h33, 3, 1, 0, 0, 1, 0);
    rd(2'd0, v); check("R8 rbr", v, 8'h33);
    rd(2'd3, v); check("R8 lsr kept", v, 8'h64);
    rd(2'd3, v); check("R8 lsr cleared", v, 8'h60);

    // R11 overrun
    wr(2'd1, 8'h00); wr(2'd2, 8'h03);
    send(8'h11, 3, 0, 0, 0, 0, 0);
    send(8'h22, 3, 0, 0, 0, 0, 0);
    send(8'h33, 3, 0, 0, 0, 0, 0);
    rd(2'd3, v); check("R11 lsr", v, 8'h63);
    rd(2'd3, v); check("R11 lsr cleared", v, 8'h61);
    rd(2'd0, v); check("R11 rbr0", v, 8'h11);
    rd(2'd0, v); check("R11 rbr1", v, 8'h22);
    rd(2'd3, v); check("R11 dropped", v, 8'h60);

    // R6 break
    wr(2'd1, 8'h04);
    @(negedge clk); rx_line = 1'b0;
    repeat (12 * BIT_CLKS) @(negedge clk);
    idle_bits(2);
    check("R6 irq", irq, 1);
    rd(2'd3, v); check("R6 lsr", v, 8'h79);
    rd(2'd0, v); check("R6 rbr", v, 8'h00);
    rd(2'd3, v); check("R6 single char", v, 8'h60);

    // random frames
    for (int n = 0; n < 24; n++) begin
      int wl = int'($urandom % 4);
      logic pen = 1'($urandom % 2);
      logic even = 1'($urandom % 2);
      logic stick = pen & 1'($urandom % 2);
      logic bpar = pen & ($urandom % 4 == 0);
      logic bstop = ($urandom % 5 == 0);
      logic [7:0] d = 8'($urandom);
      logic [7:0] ie;
      logic [7:0] m = 8'((1 << (5 + wl)) - 1);
      logic pbit = calc_par(d, wl, even, stick) ^ bpar;
      logic bi, pe, fe;
      logic [7:0] elsr;
      string tag;
      case ($urandom % 5)
        0: ie = 8'h00; 1: ie = 8'h01; 2: ie = 8'h04; 3: ie = 8'h05; default: ie = 8'h0A;
      endcase
      if (n == 3) begin d = 8'h00; bstop = 1; bpar = 0; pen = 0; stick = 0; end
      pbit = calc_par(d, wl, even, stick) ^ bpar;
      bi = bstop && ((d & m) == 0) && (!pen || !pbit);
      fe = bstop;
      pe = pen && bpar && !bi;
      elsr = 8'h61 | {3'b000, bi, fe, pe, 2'b00};
      tag = bi ? "R6" : fe ? "R5" : pe ? (stick ? "R4" : "R3") : "R2";
      wr(2'd1, ie);
      wr(2'd2, {2'b00, stick, even, pen, 1'b0, 2'(wl)});
      send(d, wl, pen, even, stick, bpar, bstop);
      check("R12 irq before status read", irq, int'(ie[0] | (ie[2] & (pe | fe | bi))));
      rd(2'd3, v); check({tag, " lsr"}, v, elsr);
      check("R12 irq after status read", irq, int'(ie[0]));
      rd(2'd3, v); check("R8 lsr reread", v, 8'h61);
      rd(2'd0, v); check({tag, " rbr"}, v, bi ? 0 : int'(d & m));
      rd(2'd3, v); check("R10 lsr empty", v, 8'h60);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule